// File: doc/BRIEF.md
# Serial ADC Conversion Master

This block is the host side of a 4-wire serial link to a 12-bit multichannel successive-approximation converter. It accepts a start request that carries a channel number and an input-mode flag. The flag selects single-ended or pseudo-differential input. The block then runs one complete 24-clock transfer on its own and returns the 12-bit result together with a one-cycle done pulse.

The link uses clock-idles-low signalling. Chip select goes low, and the command is padded with leading zeros so that the 12 result bits land in the last 12 of the 24 clocks. The serial clock is derived from the system clock. Each phase lasts a programmable number of system cycles, which holds the high and low times and the select-to-first-edge setup above their minimums. After each transfer, chip select stays high for a programmable guard time before the next request is taken.

Top module: `adcm_ctrl`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, busy is 0 and done is 0.
- R2: A start request seen while busy is 0 drives cs_n low and busy high on the next clock edge. That same edge latches chan and single for the transfer.
- R3: The serial clock is 0 whenever cs_n is 1. After cs_n falls, sclk stays low for DIV_HALF cycles. It then gives exactly 24 pulses, each DIV_HALF cycles high followed by DIV_HALF cycles low.
- R4: mosi changes only while sclk is low. The bits presented at the 24 rising edges are, in order: five 0s, a 1 (start), the single flag (1 = single-ended, 0 = pseudo-differential), chan[2], chan[1], chan[0], then fourteen 0s.
- R5: miso is sampled at each rising sclk edge. The sample at rising edge 12 is the null bit. The samples at rising edges 13 to 24 are the code, MSB first.
- R6: On the clock edge that ends the low phase after the 24th pulse, cs_n returns to 1. At that edge done pulses for exactly one cycle, and code takes the captured 12 bits.
- R7: null_err is updated together with done. It is 1 when the captured null bit was 1, and code is still reported in that case.
- R8: busy stays 1 from the accepting edge until cs_n has been 1 for CSH_CYC cycles. A request held high is accepted again only after that.
- R9: A start request while busy is 1 has no effect on the running transfer, on the command it sends, or on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request |
| chan | input | 3 | Channel number |
| single | input | 1 | 1 = single-ended, 0 = pseudo-differential |
| sclk | output | 1 | Serial clock to converter |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Command data to converter |
| miso | input | 1 | Result data from converter |
| busy | output | 1 | Transfer or guard time in progress |
| done | output | 1 | One-cycle result-valid pulse |
| code | output | 12 | Captured conversion result |
| null_err | output | 1 | Null bit was not zero |

## Verification
The embedded assertions check several rules on every cycle. The serial clock stays low while select is high. mosi never moves while sclk is high. done is a single cycle and only appears with select high and busy set. Select is never low without busy, and a request seen while busy never causes select to fall. The bench model predicts the exact cycle positions of every select, clock and done edge, checks them each cycle, and catches any re-triggering of a transfer in flight. Only the bench scenarios can show the command bit order, the choice of result bits from the 24 samples, and the null-bit error path, because these depend on what the converter model sends back.

// File: rtl/adcm_pkg.sv
package adcm_pkg;
  localparam int FRAME_CLKS = 24;
  localparam int LEAD_ZEROS = 5;
  localparam int CODE_W     = 12;
  localparam int CH_W       = 3;
  localparam int TAIL_ZEROS = FRAME_CLKS - LEAD_ZEROS - 2 - CH_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_GUARD
  } adcm_state_t;

  function automatic logic [FRAME_CLKS-1:0] cmd_word(input logic single,
                                                      input logic [CH_W-1:0] ch);
    return {{LEAD_ZEROS{1'b0}}, 1'b1, single, ch, {TAIL_ZEROS{1'b0}}};
  endfunction
endpackage

// File: rtl/adcm_tick.sv
module adcm_tick #(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  assign tick = en && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adcm_shreg.sv
module adcm_shreg #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic         shift_out,
  input  logic         shift_in,
  input  logic         miso,
  output logic         mosi,
  output logic [N-1:0] rx
);
  logic [N-1:0] tx;

  assign mosi = tx[N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx <= '0;
      rx <= '0;
    end else if (load) begin
      tx <= load_val;
      rx <= '0;
    end else begin
      if (shift_out) tx <= {tx[N-2:0], 1'b0};
      if (shift_in)  rx <= {rx[N-2:0], miso};
    end
  end
endmodule

// File: rtl/adcm_ctrl.sv
module adcm_ctrl
  import adcm_pkg::*;
#(
  parameter int DIV_HALF = 25,
  parameter int CSH_CYC  = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CH_W-1:0]   chan,
  input  logic              single,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] code,
  output logic              null_err
);
  localparam int BC_W = $clog2(FRAME_CLKS + 1);
  localparam int GC_W = $clog2(CSH_CYC + 1);

  adcm_state_t     st;
  logic [BC_W-1:0] bitcnt;
  logic [GC_W-1:0] gcnt;
  logic            tick, accept, last_low, sh_out, sh_in;
  logic [FRAME_CLKS-1:0] rx;

  assign accept   = (st == ST_IDLE) && start;
  assign last_low = (bitcnt == BC_W'(FRAME_CLKS));
  assign sh_out   = (st == ST_HIGH) && tick;
  assign sh_in    = tick && ((st == ST_LEAD) || ((st == ST_LOW) && !last_low));

  adcm_tick #(.LIMIT(DIV_HALF)) u_tick (
    .clk(clk), .rst(rst),
    .en((st == ST_LEAD) || (st == ST_HIGH) || (st == ST_LOW)),
    .tick(tick)
  );

  adcm_shreg #(.N(FRAME_CLKS)) u_shreg (
    .clk(clk), .rst(rst), .load(accept), .load_val(cmd_word(single, chan)),
    .shift_out(sh_out), .shift_in(sh_in), .miso(miso), .mosi(mosi), .rx(rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      code     <= '0;
      null_err <= 1'b0;
      bitcnt   <= '0;
      gcnt     <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          st     <= ST_LEAD;
          cs_n   <= 1'b0;
          busy   <= 1'b1;
          bitcnt <= '0;
        end
        ST_LEAD: if (tick) begin
          st   <= ST_HIGH;
          sclk <= 1'b1;
        end
        ST_HIGH: if (tick) begin
          st     <= ST_LOW;
          sclk   <= 1'b0;
          bitcnt <= bitcnt + 1'b1;
        end
        ST_LOW: if (tick) begin
          if (last_low) begin
            st       <= ST_GUARD;
            cs_n     <= 1'b1;
            done     <= 1'b1;
            code     <= rx[CODE_W-1:0];
            null_err <= rx[CODE_W];
            gcnt     <= '0;
          end else begin
            st   <= ST_HIGH;
            sclk <= 1'b1;
          end
        end
        ST_GUARD: begin
          if (gcnt == GC_W'(CSH_CYC - 1)) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk); // R3
  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (bitcnt == BC_W'(FRAME_CLKS))); // R3
  AST_MOSI_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi) |-> !sclk); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && busy)); // R6
  AST_CS_BUSY: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !$fell(cs_n)); // R9
endmodule

// File: tb/adcm_ctrl_tb.sv
module adcm_ctrl_tb;
  localparam int D   = 3;
  localparam int CSH = 7;
  localparam int LOW_END = 49 * D;
  localparam int BUSY_END = LOW_END + CSH;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, single = 1'b0, miso = 1'b1;
  logic [2:0] chan = '0;
  logic sclk, cs_n, mosi, busy, done, null_err;
  logic [11:0] code;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  adcm_ctrl #(.DIV_HALF(D), .CSH_CYC(CSH)) u_dut (
    .clk(clk), .rst(rst), .start(start), .chan(chan), .single(single),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .busy(busy),
    .done(done), .code(code), .null_err(null_err)
  );

  // converter model
  logic [11:0] conv_code = '0;
  logic        conv_null = 1'b0;
  logic [23:0] din_cap = '0;
  int rcnt = 0, fcnt = 0;

  always @(negedge cs_n) begin rcnt = 0; fcnt = 0; miso = 1'b1; end
  always @(posedge sclk) if (!cs_n) begin rcnt++; din_cap = {din_cap[22:0], mosi}; end
  always @(negedge sclk) if (!cs_n) begin
    fcnt++;
    if (fcnt < 11)       miso = 1'b1;
    else if (fcnt == 11) miso = conv_null;
    else if (fcnt <= 23) miso = conv_code[23 - fcnt];
    else                 miso = 1'b0;
  end

  // cycle reference model
  bit act = 0;
  int n = 0;
  always @(posedge clk) begin
    if (rst) act = 0;
    else if (!act && start) begin act = 1; n = 0; end
    else if (act) begin n++; if (n >= BUSY_END) act = 0; end
  end

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v,
                     input string what);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    logic e_cs, e_sclk, e_busy, e_done;
    e_busy = act;
    e_cs   = !(act && n < LOW_END);
    e_sclk = act && n >= D && n < LOW_END && (((n - D) / D) % 2 == 0);
    e_done = act && n == LOW_END;
    chk("R2", cs_n, e_cs, "cs_n");
    chk("R3", sclk, e_sclk, "sclk");
    chk("R8", busy, e_busy, "busy");
    chk("R6", done, e_done, "done");
  end

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic frame(input logic [2:0] ch, input logic sg, input logic [11:0] cv,
                       input logic nb, input bit poke);
    conv_code = cv; conv_null = nb;
    @(negedge clk); chan = ch; single = sg; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      chan = ~ch; single = ~sg; start = 1'b1;   // R9: request while busy
      @(negedge clk); start = 1'b0;
    end
    wait_done();
    chk("R5", code, cv, "code");
    chk("R7", null_err, nb, "null_err");
    chk("R4", din_cap, {5'b0, 1'b1, sg, ch, 14'b0}, "command");
    chk("R3", rcnt, 24, "pulses");
    while (busy) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {cs_n, sclk, mosi, busy, done}, 5'b10000, "reset outputs");
    frame(3'd5, 1'b1, 12'hA5C, 1'b0, 0);   // single-ended
    frame(3'd2, 1'b0, 12'hFFF, 1'b0, 0);   // pseudo-differential, all ones
    frame(3'd0, 1'b1, 12'h001, 1'b0, 1);   // R9 request mid-transfer
    frame(3'd7, 1'b0, 12'h3C3, 1'b1, 0);   // R7 null bit high
    frame(3'd6, 1'b1, 12'h000, 1'b0, 0);   // all zeros
    // R8 request held high: two back-to-back frames
    conv_code = 12'h5A5; conv_null = 1'b0;
    @(negedge clk); chan = 3'd3; single = 1'b1; start = 1'b1;
    wait_done();
    chk("R8", code, 12'h5A5, "held code 1");
    @(negedge clk);
    wait_done();
    chk("R8", code, 12'h5A5, "held code 2");
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R1", {cs_n, sclk, mosi}, 3'b100, "idle outputs");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule